// File: doc/BRIEF.md
# Compare/Capture Event Timer

This block is a free-running up-counter with a small word-addressed register port. Software preloads the counter, picks a tick rate and an end-of-count policy, and starts it. As the count advances, the block raises event flags when the counter wraps past its all-ones value, when it reaches a programmed compare value, and when a selected edge arrives on an external capture input. At a capture edge the current count is also latched into a capture register.

The same events can drive a waveform pin. A trigger-mode field selects which events act on the pin: none, wrap only, or wrap and compare. A second bit chooses between toggling the pin on each selected event and emitting a one-cycle pulse away from a programmable idle level. Event flags are cleared by writing ones to them, and any flag whose enable bit is set drives a single level interrupt. None of the interfaces carries a data stream, so all pins are plain control and status with no valid/ready handshake. Register writes take effect at the clock edge on which `reg_wr` is high. Reads are combinational from the addressed register.

Register words (3-bit `reg_addr`): 0 control, 1 counter, 2 reload value, 3 reload strobe, 4 compare value, 5 capture (read-only), 6 event flags, 7 interrupt enables. Control bits: 0 run, 1 reload-on-wrap, [4:2] divide ratio r, 5 divider enable, 6 compare enable, 7 pin idle level, [9:8] capture edge, [11:10] pin trigger mode, 12 toggle (1) or pulse (0), 13 capture one-shot, 14 pin set to input. Flag and enable bits: 0 compare, 1 wrap, 2 capture.

Top module: `cmpcap_timer`

## Requirements
- R1: After reset every register reads zero, `irq` and `pwm_out` are 0 and `pwm_oe` is 1.
- R2: Writing the counter word loads the count, and a later control write with bit 0 set makes it advance by one on each enabled tick. The first tick comes on the edge after the control write.
- R3: With control bit 5 set, the count advances once per 2^(r+1) clocks, r being control bits [4:2]. With bit 5 clear it advances every clock.
- R4: A tick at count all-ones sets flag bit 1. With control bit 1 set the counter then takes the reload value. Otherwise it goes to 0 and control bit 0 clears.
- R5: With control bit 6 set, a tick that brings the count to the compare value sets flag bit 0. With bit 6 clear no compare flag is set.
- R6: Any write to word 3 copies the reload value into the counter on that edge.
- R7: Control bits [9:8] pick capture edges (0 none, 1 rising, 2 falling, 3 both). A selected edge of `cap_in` latches the count into word 5 and sets flag bit 2. With control bit 13 set, edges are ignored while flag bit 2 is set.
- R8: With pin trigger mode [11:10] = 1 (wrap) or 2 (wrap or compare), each selected event toggles `pwm_out` when bit 12 is 1. When bit 12 is 0 it drives `pwm_out` to the inverse of idle level bit 7 for one cycle. In mode 0, `pwm_out` follows bit 7.
- R9: `pwm_oe` is the inverse of control bit 14.
- R10: Writing 1 to a flag bit clears it, writing 0 leaves it, and a new event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some flag bit and its enable bit in word 7 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the addressed word |
| cap_in | input | 1 | Capture input, synchronous to clk |
| pwm_out | output | 1 | Waveform pin output |
| pwm_oe | output | 1 | Waveform pin drive enable |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is the wrap from all-ones: counting there from reset would take billions of cycles. The stimulus therefore preloads the counter a few steps below the top and then starts it. This also lets a wrap and a compare hit fall on the same tick, with the reload value equal to the compare value. The one-shot capture case needs a flag that is deliberately left unacknowledged across a second edge. The stimulus gets there by chaining capture edges without clearing flags, then acknowledging the flag and applying one more edge to show that capture resumes.

// File: rtl/cmpcap_timer_pkg.sv
package cmpcap_timer_pkg;
  localparam int CTRL_W  = 15;
  localparam int RATIO_W = 3;
  localparam int ADDR_W  = 3;
  localparam int FLAG_W  = 3;

  // control bit positions
  localparam int B_RUN     = 0;
  localparam int B_AREL    = 1;
  localparam int B_RATIO   = 2;
  localparam int B_DIV_EN  = 5;
  localparam int B_CMP_EN  = 6;
  localparam int B_IDLE    = 7;
  localparam int B_CAP     = 8;
  localparam int B_TRIG    = 10;
  localparam int B_TOGGLE  = 12;
  localparam int B_ONESHOT = 13;
  localparam int B_PIN_IN  = 14;

  // flag bit positions
  localparam int F_CMP  = 0;
  localparam int F_WRAP = 1;
  localparam int F_CAPT = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_LOAD  = 3'd2,
    A_STRB  = 3'd3,
    A_CMP   = 3'd4,
    A_CAPT  = 3'd5,
    A_FLAG  = 3'd6,
    A_IEN   = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    PT_NONE     = 2'd0,
    PT_WRAP     = 2'd1,
    PT_WRAP_CMP = 2'd2,
    PT_RSVD     = 2'd3
  } pin_trig_e;
endpackage

// File: rtl/cmpcap_prescale.sv
module cmpcap_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               div_en,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  localparam int DIV_W = 1 << RATIO_W;
  localparam logic [RATIO_W-1:0] TOP_SH = RATIO_W'(DIV_W - 1);

  logic [DIV_W-1:0]   pcnt;
  logic [DIV_W-1:0]   mask;
  logic [RATIO_W-1:0] shamt;

  always_comb begin
    shamt = TOP_SH - ratio;
    mask  = {DIV_W{1'b1}} >> shamt;
    tick  = run & (~div_en | ((pcnt & mask) == mask));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pcnt <= '0;
    else                pcnt <= pcnt + 1'b1;
  end

  // R3
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_en && tick) |=> (!tick || !div_en));
endmodule

// File: rtl/cmpcap_counter.sv
module cmpcap_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             autoreload,
  input  logic             cmp_en,
  input  logic             wr_cnt,
  input  logic             wr_reload,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cmp_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             cmp_evt
);
  logic             at_top;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    at_top   = &count;
    wrap_evt = tick & at_top;
    nxt      = at_top ? (autoreload ? load_val : '0) : count + 1'b1;
    cmp_evt  = tick & cmp_en & (nxt == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         count <= '0;
    else if (wr_cnt)    count <= wdata;
    else if (wr_reload) count <= load_val;
    else if (tick)      count <= nxt;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_top && !wr_cnt && !wr_reload) |=> count == $past(count) + 1'b1);
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !autoreload && !wr_cnt && !wr_reload) |=> count == '0);
  // R6
  strobe_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && !wr_cnt) |=> count == $past(load_val));
endmodule

// File: rtl/cmpcap_capture.sv
module cmpcap_capture #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic [1:0]       edge_sel,
  input  logic             one_shot,
  input  logic             flag,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_evt
);
  logic prev;
  logic hit;

  // edge_sel bit 0 selects rising, bit 1 selects falling
  always_comb begin
    hit     = (edge_sel[0] & cap_in & ~prev) | (edge_sel[1] & ~cap_in & prev);
    cap_evt = hit & (~one_shot | ~flag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      cap_val <= '0;
    end else begin
      prev <= cap_in;
      if (cap_evt) cap_val <= count;
    end
  end

  // R7
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_val == $past(count));
  // R7
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (one_shot && flag) |=> $stable(cap_val));
endmodule

// File: rtl/cmpcap_pin.sv
module cmpcap_pin
  import cmpcap_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrap_evt,
  input  logic      cmp_evt,
  input  pin_trig_e mode,
  input  logic      toggle,
  input  logic      idle_lvl,
  output logic      pwm
);
  logic evt;
  logic active;

  always_comb begin
    active = (mode == PT_WRAP) || (mode == PT_WRAP_CMP);
    evt    = ((mode == PT_WRAP) & wrap_evt) |
             ((mode == PT_WRAP_CMP) & (wrap_evt | cmp_evt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pwm <= 1'b0;
    else if (!active) pwm <= idle_lvl;
    else if (evt)     pwm <= toggle ? ~pwm : ~idle_lvl;
    else if (!toggle) pwm <= idle_lvl;
  end

  // R8
  toggle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && toggle && !evt) |=> $stable(pwm));
  // R8
  pulse_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !toggle && evt) |=> pwm != $past(idle_lvl));
endmodule

// File: rtl/cmpcap_timer.sv
module cmpcap_timer
  import cmpcap_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              pwm_oe,
  output logic              irq
);
  localparam int PAD_CTRL = CNT_W - CTRL_W;
  localparam int PAD_FLAG = CNT_W - FLAG_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  load_q, cmp_q, count, cap_val;
  logic [FLAG_W-1:0] flag_q, ien_q, ack, evts;
  logic wr_ctrl, wr_cnt, wr_strb, wr_load, wr_cmp, wr_flag, wr_ien;
  logic tick, wrap_evt, cmp_evt, cap_evt;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    wr_cnt  = reg_wr && (reg_addr == A_COUNT);
    wr_load = reg_wr && (reg_addr == A_LOAD);
    wr_strb = reg_wr && (reg_addr == A_STRB);
    wr_cmp  = reg_wr && (reg_addr == A_CMP);
    wr_flag = reg_wr && (reg_addr == A_FLAG);
    wr_ien  = reg_wr && (reg_addr == A_IEN);
    ack     = wr_flag ? reg_wdata[FLAG_W-1:0] : '0;
    evts    = '0;
    evts[F_CMP]  = cmp_evt;
    evts[F_WRAP] = wrap_evt;
    evts[F_CAPT] = cap_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cmp_q  <= '0;
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata[CTRL_W-1:0];
      else if (wrap_evt && !ctrl_q[B_AREL]) ctrl_q[B_RUN] <= 1'b0;
      if (wr_load) load_q <= reg_wdata;
      if (wr_cmp)  cmp_q  <= reg_wdata;
      if (wr_ien)  ien_q  <= reg_wdata[FLAG_W-1:0];
      flag_q <= (flag_q & ~ack) | evts;
    end
  end

  cmpcap_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q[B_RUN]), .div_en(ctrl_q[B_DIV_EN]),
    .ratio(ctrl_q[B_RATIO +: RATIO_W]), .tick(tick));

  cmpcap_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .autoreload(ctrl_q[B_AREL]),
    .cmp_en(ctrl_q[B_CMP_EN]), .wr_cnt(wr_cnt), .wr_reload(wr_strb),
    .wdata(reg_wdata), .load_val(load_q), .cmp_val(cmp_q), .count(count),
    .wrap_evt(wrap_evt), .cmp_evt(cmp_evt));

  cmpcap_capture #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(ctrl_q[B_CAP +: 2]),
    .one_shot(ctrl_q[B_ONESHOT]), .flag(flag_q[F_CAPT]), .count(count),
    .cap_val(cap_val), .cap_evt(cap_evt));

  cmpcap_pin u_pin (
    .clk(clk), .rst_n(rst_n), .wrap_evt(wrap_evt), .cmp_evt(cmp_evt),
    .mode(pin_trig_e'(ctrl_q[B_TRIG +: 2])), .toggle(ctrl_q[B_TOGGLE]),
    .idle_lvl(ctrl_q[B_IDLE]), .pwm(pwm_out));

  always_comb begin
    pwm_oe = ~ctrl_q[B_PIN_IN];
    irq    = |(flag_q & ien_q);
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = {{PAD_CTRL{1'b0}}, ctrl_q};
      A_COUNT: reg_rdata = count;
      A_LOAD:  reg_rdata = load_q;
      A_CMP:   reg_rdata = cmp_q;
      A_CAPT:  reg_rdata = cap_val;
      A_FLAG:  reg_rdata = {{PAD_FLAG{1'b0}}, flag_q};
      A_IEN:   reg_rdata = {{PAD_FLAG{1'b0}}, ien_q};
      default: reg_rdata = '0;
    endcase
  end

  // R4
  run_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !ctrl_q[B_AREL] && !wr_ctrl) |=> !ctrl_q[B_RUN]);
  // R10
  flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && reg_wdata[F_WRAP] && !wrap_evt) |=> !flag_q[F_WRAP]);
  // R10
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q[F_WRAP]);
endmodule

// File: tb/cmpcap_timer_tb.sv
module cmpcap_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cap_in = 1'b0;
  logic        pwm_out, pwm_oe, irq;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  cmpcap_timer #(.CNT_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe), .irq(irq));

  localparam logic [2:0] W_CTRL = 3'd0, W_CNT = 3'd1, W_LOAD = 3'd2,
    W_STRB = 3'd3, W_CMP = 3'd4, W_CAPT = 3'd5, W_FLAG = 3'd6, W_IEN = 3'd7;

  typedef struct packed {
    logic [31:0] start;
    logic [31:0] load;
    logic [31:0] cmp;
    logic [14:0] ctrl;
    logic [7:0]  k;
    logic [31:0] exp_cnt;
    logic [2:0]  exp_flag;
    logic        exp_run;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'd100, 32'd0, 32'd0, 15'h0001, 8'd10, 32'd110, 3'd0, 1'b1, 4'd2},
    '{32'd0, 32'd0, 32'd0, 15'h0021, 8'd9, 32'd4, 3'd0, 1'b1, 4'd3},
    '{32'd0, 32'd0, 32'd0, 15'h0029, 8'd20, 32'd2, 3'd0, 1'b1, 4'd3},
    '{32'hFFFFFFFD, 32'd0, 32'd0, 15'h0001, 8'd5, 32'd0, 3'd2, 1'b0, 4'd4},
    '{32'hFFFFFFFD, 32'h1000, 32'd0, 15'h0003, 8'd5, 32'h1002, 3'd2, 1'b1, 4'd4},
    '{32'd50, 32'd0, 32'd55, 15'h0041, 8'd8, 32'd58, 3'd1, 1'b1, 4'd5},
    '{32'd50, 32'd0, 32'd55, 15'h0001, 8'd8, 32'd58, 3'd0, 1'b1, 4'd5},
    '{32'hFFFFFFFE, 32'd7, 32'd7, 15'h0043, 8'd3, 32'd8, 3'd3, 1'b1, 4'd4}
  };

  function automatic string rname(input logic [3:0] id);
    case (id)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(W_CTRL, d);  chk("R1 ctrl", d, 0);
    rd(W_CNT, d);   chk("R1 count", d, 0);
    rd(W_FLAG, d);  chk("R1 flags", d, 0);
    rd(W_CAPT, d);  chk("R1 capture", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pwm_out", pwm_out, 0);
    chk("R1 pwm_oe", pwm_oe, 1);

    // table of counting vectors
    for (int i = 0; i < NV; i++) begin
      wr(W_CTRL, 0);
      wr(W_FLAG, 7);
      wr(W_LOAD, VECS[i].load);
      wr(W_CMP, VECS[i].cmp);
      wr(W_CNT, VECS[i].start);
      wr(W_CTRL, 32'(VECS[i].ctrl));
      repeat (int'(VECS[i].k)) @(negedge clk);
      rd(W_CNT, d);  chk({rname(VECS[i].req), " count"}, d, VECS[i].exp_cnt);
      rd(W_FLAG, d); chk({rname(VECS[i].req), " flags"}, d, 32'(VECS[i].exp_flag));
      rd(W_CTRL, d); chk({rname(VECS[i].req), " run bit"}, 32'(d[0]), 32'(VECS[i].exp_run));
    end

    // R6 reload strobe
    wr(W_CTRL, 0);
    wr(W_FLAG, 7);
    wr(W_LOAD, 32'h77);
    wr(W_CNT, 32'h5);
    wr(W_STRB, 32'h0);
    rd(W_CNT, d); chk("R6 strobe reload", d, 32'h77);

    // R11 / R10 flags and interrupt
    wr(W_IEN, 0);
    wr(W_CNT, 32'hFFFFFFFF);
    wr(W_CTRL, 32'h1);
    @(negedge clk);
    rd(W_FLAG, d); chk("R4 wrap flag", d, 2);
    chk("R11 masked irq", irq, 0);
    wr(W_IEN, 2);
    chk("R11 enabled irq", irq, 1);
    wr(W_FLAG, 1);
    rd(W_FLAG, d); chk("R10 zero-bit write keeps flag", d, 2);
    chk("R11 irq held", irq, 1);
    wr(W_FLAG, 2);
    rd(W_FLAG, d); chk("R10 ack clears flag", d, 0);
    chk("R11 irq drops", irq, 0);
    wr(W_IEN, 0);

    // R7 capture
    wr(W_CTRL, 32'h0100);
    wr(W_CNT, 32'h33);
    cap_in = 1'b1;
    @(negedge clk);
    rd(W_CAPT, d); chk("R7 rising capture", d, 32'h33);
    rd(W_FLAG, d); chk("R7 capture flag", d, 4);
    wr(W_FLAG, 4);
    wr(W_CNT, 32'h44);
    cap_in = 1'b0;
    @(negedge clk);
    rd(W_CAPT, d); chk("R7 falling ignored in rising mode", d, 32'h33);
    rd(W_FLAG, d); chk("R7 no flag on ignored edge", d, 0);
    wr(W_CTRL, 32'h0300);
    cap_in = 1'b1;
    @(negedge clk);
    rd(W_CAPT, d); chk("R7 both-edge rise", d, 32'h44);
    wr(W_CNT, 32'h55);
    cap_in = 1'b0;
    @(negedge clk);
    rd(W_CAPT, d); chk("R7 both-edge fall", d, 32'h55);
    wr(W_CTRL, 32'h2300);
    wr(W_CNT, 32'h66);
    cap_in = 1'b1;
    @(negedge clk);
    rd(W_CAPT, d); chk("R7 one-shot blocks while flagged", d, 32'h55);
    wr(W_FLAG, 4);
    cap_in = 1'b0;
    @(negedge clk);
    rd(W_CAPT, d); chk("R7 one-shot resumes after ack", d, 32'h66);

    // R8 toggle on wrap with reload
    wr(W_CTRL, 0);
    wr(W_FLAG, 7);
    wr(W_LOAD, 32'hFFFFFFFE);
    wr(W_CNT, 32'hFFFFFFFE);
    wr(W_CTRL, 32'h1403);
    @(negedge clk);
    chk("R8 toggle before wrap", pwm_out, 0);
    @(negedge clk);
    chk("R8 toggle at first wrap", pwm_out, 1);
    repeat (2) @(negedge clk);
    chk("R8 toggle at second wrap", pwm_out, 0);

    // R8 pulse on compare, idle level high
    wr(W_CTRL, 0);
    wr(W_CMP, 32'h10);
    wr(W_CNT, 32'h0E);
    wr(W_CTRL, 32'h08C1);
    @(negedge clk);
    chk("R8 pulse idle level", pwm_out, 1);
    @(negedge clk);
    chk("R8 pulse on compare", pwm_out, 0);
    @(negedge clk);
    chk("R8 pulse returns to idle", pwm_out, 1);
    wr(W_CTRL, 32'h0080);
    @(negedge clk);
    chk("R8 mode none follows idle bit", pwm_out, 1);

    // R9 pin direction
    wr(W_CTRL, 32'h4000);
    chk("R9 pin as input", pwm_oe, 0);
    wr(W_CTRL, 0);
    chk("R9 pin as output", pwm_oe, 1);

    summary();
  end
endmodule